// File: doc/BRIEF.md
# Thread Block to Warp Partitioner

This block turns a three-dimensional thread-block shape into the list of warps that cover it. A start strobe captures the shape (width, height and depth in threads). The block forms the product of the three extents and rounds it up to a whole number of 32-lane warps. It then hands out one warp per cycle on a valid/ready handshake. Each warp carries its index and a 32-bit mask of the lanes that hold real threads. A one-cycle done pulse marks the end of the list.

Threads join warps by their flattened index. X varies fastest, then Y, then Z, so thread (x, y, z) has linear position x + y·W + z·W·H. Each group of 32 consecutive positions forms one warp. When the thread count is not a multiple of 32, only the final warp is partly filled, and only its used lanes are enabled.

A separate lookup port takes any coordinate and returns its warp index and lane number with no clock delay. It uses the shape most recently captured.

Top module: `thread_warp_partitioner`

## Requirements
- R1: After reset, out_valid, done and busy are all 0.
- R2: A start pulse seen while busy is 0 captures dim_x, dim_y and dim_z. Once out_valid is 1, out_warp_id and out_mask hold steady until a cycle in which out_ready is also 1.
- R3: Warps appear with indices 0, 1, 2 and so on, one per accepted handshake. The number of warps is ceil(dim_x·dim_y·dim_z / 32). For example, 40 threads give 2 warps and 1024 threads give 32 warps.
- R4: Enabled lanes always occupy the low bits of out_mask, starting at bit 0 (lane n is bit n). The last warp enables exactly (thread count mod 32) lanes when that remainder is nonzero. For example, 40 threads give a second-warp mask of 0x000000FF.
- R5: Every warp except the last has mask 0xFFFFFFFF. A block of exactly 32 threads gives one warp with mask 0xFFFFFFFF. A block of 1 thread gives one warp with mask 0x00000001.
- R6: done is 1 for exactly one cycle: the cycle after the handshake that accepts the last warp. out_valid is 0 in that cycle.
- R7: If any captured extent is 0, no warp is offered and done is 1 in the cycle right after the start edge.
- R8: A start pulse while busy is 1 is ignored. The warp sequence in progress keeps its indices, masks and count.
- R9: For a coordinate (q_x, q_y, q_z) inside the captured shape, q_warp_id equals floor(L/32) and q_lane equals L mod 32, where L = q_x + q_y·dim_x + q_z·dim_x·dim_y. The result is combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture shape and begin a warp list |
| dim_x | input | DIM_W | Block extent in X |
| dim_y | input | DIM_W | Block extent in Y |
| dim_z | input | DIM_W | Block extent in Z |
| busy | output | 1 | A warp list is in progress |
| out_valid | output | 1 | A warp is offered |
| out_ready | input | 1 | Consumer accepts the offered warp |
| out_warp_id | output | WID_W | Index of the offered warp |
| out_mask | output | 32 | Active-lane mask of the offered warp |
| done | output | 1 | One-cycle end-of-list pulse |
| q_x | input | DIM_W | Lookup coordinate X |
| q_y | input | DIM_W | Lookup coordinate Y |
| q_z | input | DIM_W | Lookup coordinate Z |
| q_warp_id | output | WID_W | Warp index of the lookup coordinate |
| q_lane | output | 5 | Lane of the lookup coordinate |

## Verification
Some properties are checked by assertions on every cycle:
- offered warps stay steady under backpressure;
- indices rise by one after each accepted non-final warp;
- masks are always a nonzero run of low bits;
- non-final warps are full;
- done never lasts two cycles.

Other properties can only be shown by the bench's scenarios, which compare against its own arithmetic:
- the exact warp count and the tail-mask width for each shape;
- the empty-shape case;
- immunity to a start pulse in mid-list;
- the coordinate lookup.

// File: rtl/twp_pkg.sv
package twp_pkg;
  localparam int unsigned LANES  = 32;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_EMIT = 2'd1, ST_FIN = 2'd2} seq_state_e;

  // Mask with the lowest n bits set (n saturates at LANES).
  function automatic logic [LANES-1:0] low_lanes(input int unsigned n);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/twp_shape_reg.sv
module twp_shape_reg
  import twp_pkg::*;
#(
  parameter int unsigned DIM_W = 11,
  localparam int unsigned TOT_W = 3 * DIM_W,
  localparam int unsigned WID_W = TOT_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DIM_W-1:0]  dx,
  input  logic [DIM_W-1:0]  dy,
  input  logic [DIM_W-1:0]  dz,
  output logic              empty_now,
  output logic [DIM_W-1:0]  dx_q,
  output logic [DIM_W-1:0]  dy_q,
  output logic [DIM_W-1:0]  dz_q,
  output logic [WID_W-1:0]  nwarps_q,
  output logic [LANES-1:0]  tail_q
);
  logic [TOT_W-1:0] total;
  logic [TOT_W:0]   rounded;
  logic [LANE_W-1:0] rem;

  always_comb begin
    total   = TOT_W'(dx) * TOT_W'(dy) * TOT_W'(dz);
    rounded = {1'b0, total} + (TOT_W+1)'(LANES - 1);
    rem     = total[LANE_W-1:0];
  end

  assign empty_now = (dx == '0) || (dy == '0) || (dz == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dx_q     <= '0;
      dy_q     <= '0;
      dz_q     <= '0;
      nwarps_q <= '0;
      tail_q   <= '0;
    end else if (load) begin
      dx_q     <= dx;
      dy_q     <= dy;
      dz_q     <= dz;
      nwarps_q <= rounded[TOT_W-1:LANE_W];
      tail_q   <= (rem == '0) ? low_lanes(LANES) : low_lanes(int'(rem));
    end
  end
endmodule

// File: rtl/twp_warp_seq.sv
module twp_warp_seq
  import twp_pkg::*;
#(
  parameter int unsigned WID_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              launch_empty,
  input  logic [WID_W-1:0]  nwarps,
  input  logic [LANES-1:0]  tail_mask,
  input  logic              ready,
  output logic              busy,
  output logic              valid,
  output logic [WID_W-1:0]  warp_id,
  output logic [LANES-1:0]  mask,
  output logic              done
);
  seq_state_e state;
  logic [WID_W-1:0] idx;
  logic is_last, fire, fire_last;
  logic [LANES-1:0] mask_inc;

  assign valid     = (state == ST_EMIT);
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);
  assign is_last   = (idx == nwarps - 1'b1);
  assign fire      = valid && ready;
  assign fire_last = fire && is_last;
  assign warp_id   = idx;
  assign mask      = is_last ? tail_mask : low_lanes(LANES);
  assign mask_inc  = mask + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          idx   <= '0;
          state <= launch_empty ? ST_FIN : ST_EMIT;
        end
        ST_EMIT: if (fire) begin
          if (is_last) state <= ST_FIN;
          else idx <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: offered warp holds while stalled
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(warp_id) && $stable(mask));
  // R3: indices climb by one
  a_r3_ascend: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !fire_last |=> valid && (warp_id == $past(warp_id) + 1'b1));
  // R4: mask is a nonzero run starting at lane 0
  a_r4_low_run: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (mask != '0) && ((mask & mask_inc) == '0));
  // R5: non-final warps are fully populated
  a_r5_full_body: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !is_last |-> (&mask));
  // R6: done is a single-cycle pulse following the final handshake
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after: assert property (@(posedge clk) disable iff (!rst_n)
    fire_last |=> done && !valid);
endmodule

// File: rtl/twp_coord_map.sv
module twp_coord_map
  import twp_pkg::*;
#(
  parameter int unsigned DIM_W = 11,
  localparam int unsigned TOT_W = 3 * DIM_W,
  localparam int unsigned WID_W = TOT_W - LANE_W
) (
  input  logic [DIM_W-1:0]  dx,
  input  logic [DIM_W-1:0]  dy,
  input  logic [DIM_W-1:0]  cx,
  input  logic [DIM_W-1:0]  cy,
  input  logic [DIM_W-1:0]  cz,
  output logic [WID_W-1:0]  warp_id,
  output logic [LANE_W-1:0] lane
);
  function automatic logic [TOT_W-1:0] flatten(
    input logic [DIM_W-1:0] x, input logic [DIM_W-1:0] y, input logic [DIM_W-1:0] z,
    input logic [DIM_W-1:0] w, input logic [DIM_W-1:0] h);
    logic [TOT_W-1:0] plane;
    plane = TOT_W'(w) * TOT_W'(h);
    return TOT_W'(x) + TOT_W'(y) * TOT_W'(w) + TOT_W'(z) * plane;
  endfunction

  logic [TOT_W-1:0] lin;
  assign lin     = flatten(cx, cy, cz, dx, dy);
  assign warp_id = lin[TOT_W-1:LANE_W];
  assign lane    = lin[LANE_W-1:0];
endmodule

// File: rtl/thread_warp_partitioner.sv
module thread_warp_partitioner
  import twp_pkg::*;
#(
  parameter int unsigned DIM_W = 11,
  localparam int unsigned TOT_W = 3 * DIM_W,
  localparam int unsigned WID_W = TOT_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  dim_x,
  input  logic [DIM_W-1:0]  dim_y,
  input  logic [DIM_W-1:0]  dim_z,
  output logic              busy,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WID_W-1:0]  out_warp_id,
  output logic [31:0]       out_mask,
  output logic              done,
  input  logic [DIM_W-1:0]  q_x,
  input  logic [DIM_W-1:0]  q_y,
  input  logic [DIM_W-1:0]  q_z,
  output logic [WID_W-1:0]  q_warp_id,
  output logic [4:0]        q_lane
);
  logic launch, launch_empty;
  logic [DIM_W-1:0] dx_q, dy_q, dz_q;
  logic [WID_W-1:0] nwarps_q;
  logic [LANES-1:0] tail_q;

  assign launch = start && !busy;

  twp_shape_reg #(.DIM_W(DIM_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .dx(dim_x), .dy(dim_y), .dz(dim_z), .empty_now(launch_empty),
    .dx_q(dx_q), .dy_q(dy_q), .dz_q(dz_q),
    .nwarps_q(nwarps_q), .tail_q(tail_q)
  );

  twp_warp_seq #(.WID_W(WID_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_empty(launch_empty),
    .nwarps(nwarps_q), .tail_mask(tail_q), .ready(out_ready),
    .busy(busy), .valid(out_valid), .warp_id(out_warp_id),
    .mask(out_mask), .done(done)
  );

  twp_coord_map #(.DIM_W(DIM_W)) u_map (
    .dx(dx_q), .dy(dy_q), .cx(q_x), .cy(q_y), .cz(q_z),
    .warp_id(q_warp_id), .lane(q_lane)
  );

  // R1: nothing offered or finished straight out of reset
  a_r1_quiet_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid && !done && !busy);
  // R8: a busy block ignores start and keeps its shape
  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(dx_q) && $stable(dy_q) && $stable(dz_q));
  // R7: empty shape never offers a warp
  a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
    launch && launch_empty |=> done && !out_valid);
  // R9: lookup lane stays within a warp (sanity on the map's split)
  a_r9_lane_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (q_x == '0 && q_y == '0 && q_z == '0) |-> (q_warp_id == '0 && q_lane == '0));
endmodule

// File: tb/thread_warp_partitioner_tb.sv
module thread_warp_partitioner_tb;
  localparam int DIM_W = 11;
  localparam int WID_W = 3 * DIM_W - 5;

  logic clk = 0, rst_n = 0, start = 0, out_ready = 0;
  logic [DIM_W-1:0] dim_x = 0, dim_y = 0, dim_z = 0, q_x = 0, q_y = 0, q_z = 0;
  logic busy, out_valid, done;
  logic [WID_W-1:0] out_warp_id, q_warp_id;
  logic [31:0] out_mask;
  logic [4:0] q_lane;
  int total = 0, bad = 0;
  int unsigned seed = 32'd1234;

  always #2.5 clk = ~clk;

  thread_warp_partitioner #(.DIM_W(DIM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dim_x(dim_x), .dim_y(dim_y), .dim_z(dim_z),
    .busy(busy), .out_valid(out_valid), .out_ready(out_ready), .out_warp_id(out_warp_id),
    .out_mask(out_mask), .done(done), .q_x(q_x), .q_y(q_y), .q_z(q_z),
    .q_warp_id(q_warp_id), .q_lane(q_lane)
  );

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic longint n_warps(input int x, input int y, input int z);
    longint t = longint'(x) * y * z;
    return (t / 32) + ((t % 32) != 0 ? 1 : 0);
  endfunction

  function automatic longint warp_mask(input longint t, input longint w);
    longint used = t - w * 32;
    if (used >= 32) return 64'hFFFF_FFFF;
    return (64'd1 << used) - 1;
  endfunction

  // Run one block; inject a start at warp index inj (-1 for none)
  task automatic run_block(input int x, input int y, input int z, input int rdy_pct, input int inj);
    longint t = longint'(x) * y * z;
    longint nw = n_warps(x, y, z);
    longint w = 0;
    int guard = 0;
    @(negedge clk);
    dim_x = DIM_W'(x); dim_y = DIM_W'(y); dim_z = DIM_W'(z); start = 1;
    @(negedge clk);
    start = 0;
    if (nw == 0) begin
      check("R7 done right after start", done, 1);
      check("R7 no warp offered", out_valid, 0);
      @(negedge clk);
      check("R6 done single cycle", done, 0);
      return;
    end
    while (w < nw && guard < 5000) begin
      guard++;
      out_ready = (($urandom(seed) % 100) < rdy_pct);
      seed = seed + 1;
      if (inj >= 0 && w == inj) begin
        start = 1; dim_x = 1; dim_y = 1; dim_z = 1;
      end else start = 0;
      #0.1;
      if (out_valid !== 1'b1) check("R2 warp offered", out_valid, 1);
      if (out_ready) begin
        check(inj >= 0 ? "R8 id unaffected" : "R3 warp index", out_warp_id, w);
        check(w == nw - 1 ? "R4 tail mask" : "R5 body mask", out_mask, warp_mask(t, w));
        w++;
      end
      @(negedge clk);
    end
    start = 0; out_ready = 0;
    dim_x = DIM_W'(x); dim_y = DIM_W'(y); dim_z = DIM_W'(z);
    check("R6 done after last warp", done, 1);
    check("R6 no warp with done", out_valid, 0);
    check("R3 warp count", w, nw);
    @(negedge clk);
    check("R6 done single cycle", done, 0);
  endtask

  task automatic probe(input int x, input int y, input int z, input int dx, input int dy);
    longint lin = longint'(x) + longint'(y) * dx + longint'(z) * dx * dy;
    q_x = DIM_W'(x); q_y = DIM_W'(y); q_z = DIM_W'(z);
    #0.5;
    check("R9 lookup warp", q_warp_id, lin / 32);
    check("R9 lookup lane", q_lane, lin % 32);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", out_valid, 0);
    check("R1 reset done", done, 0);
    check("R1 reset busy", busy, 0);
    rst_n = 1;
    run_block(40, 1, 1, 100, -1);   // R4: tail 0xFF
    run_block(32, 1, 1, 50, -1);    // R5: one full warp
    run_block(1, 1, 1, 30, -1);     // R5: single lane
    run_block(8, 8, 16, 70, -1);    // R3: 1024 -> 32 warps
    run_block(0, 5, 3, 100, -1);    // R7
    run_block(7, 3, 0, 100, -1);    // R7
    run_block(10, 5, 3, 40, 1);     // R8: start while busy
    run_block(5, 3, 2, 60, -1);
    for (int p = 0; p < 6; p++) probe(p % 5, p % 3, p % 2, 5, 3);  // R9
    for (int i = 0; i < 30; i++) begin
      int x, y, z;
      x = 1 + int'($urandom(seed) % 80); seed = seed + 3;
      y = 1 + int'($urandom(seed) % 4);  seed = seed + 5;
      z = 1 + int'($urandom(seed) % 3);  seed = seed + 7;
      run_block(x, y, z, 20 + i * 2, (i % 7 == 3) ? 0 : -1);
      for (int k = 0; k < 3; k++) begin
        int px, py, pz;
        px = int'($urandom(seed) % x); seed = seed + 11;
        py = int'($urandom(seed) % y); seed = seed + 13;
        pz = int'($urandom(seed) % z); seed = seed + 17;
        probe(px, py, pz, x, y);
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule